// File: doc/BRIEF.md
# Register Select Mask Sequencer

This block sits behind the register-select location of a floating-point coprocessor interface. When the main processor is told to move several floating-point data registers, the coprocessor issues a transfer-multiple primitive. At that moment the block captures an 8-bit mask that names the data registers to be moved. The processor then reads the location once and gets back a 16-bit word with the mask in the upper byte. Any access to the location outside that single-read window is a protocol violation. The violation is latched in a sticky flag.

After a legal read, the block counts the ones in the mask. Each selected register is 12 bytes wide, so the block schedules three 32-bit transfers per register. It then steps through them, one on each cycle in which the transfer side is ready. For every transfer it presents the data-register number and the word number within that register, so that storage outside the block can supply or accept the long word. A mask of zero finishes at once, with no transfers.

Top module: `regsel_xfer_seq`

## Requirements
- R1: While a read is strobed inside the legal window, `rd_data_o` equals {mask, 8'h00}, with the captured mask in bits 15:8. Bits 7:0 are always zero, and the whole bus is zero whenever no legal read is strobed.
- R2: The read window opens on the cycle after `prim_issue_i` and stays open until the first read. A read strobed in the same cycle as `prim_issue_i` is judged against the window as it stood before that primitive.
- R3: A read strobed while the window is closed sets the violation flag. This includes a second read after a legal one. Such a read leaves the transfer count unchanged.
- R4: Any strobe of `wr_stb_i` sets the violation flag. It neither opens nor closes the read window.
- R5: The violation flag stays set until reset or a cycle with `viol_clr_i` high. If a violating access and `viol_clr_i` fall in the same cycle, the flag ends up set.
- R6: On the cycle after a legal read, `remain_o` equals three times the number of ones in the mask. A zero mask leaves `remain_o` at zero, and the block returns to idle.
- R7: Each cycle with `xfer_rdy_i` high and `remain_o` non-zero lowers `remain_o` by one. `remain_o` holds while `xfer_rdy_i` is low, and it stays zero when no transfer is pending.
- R8: During a transfer, `reg_idx_o` is the highest-numbered mask bit not yet finished. `word_idx_o` counts 0, 1, 2 within that register and wraps to 0 when the block moves down to the next selected register.
- R9: A `prim_issue_i` during a transfer abandons it. On the next cycle `remain_o` and `word_idx_o` are zero, the new mask is captured, and the window is open.
- R10: After reset the violation flag, `remain_o`, `reg_idx_o`, `word_idx_o` and `rd_data_o` are all zero, and the window is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| prim_issue_i | input | 1 | Pulse: transfer-multiple primitive issued; captures `mask_i` |
| mask_i | input | 8 | Data-register selection mask, bit n selects register n |
| rd_stb_i | input | 1 | Read strobe for the register-select location |
| wr_stb_i | input | 1 | Write strobe for the register-select location (always illegal) |
| viol_clr_i | input | 1 | Clears the sticky violation flag |
| xfer_rdy_i | input | 1 | One long word is moved on each cycle this is high during a transfer |
| rd_data_o | output | 16 | Read data: mask in 15:8, zeros in 7:0 |
| viol_o | output | 1 | Sticky protocol-violation flag |
| remain_o | output | 5 | Long-word transfers still pending |
| reg_idx_o | output | 3 | Data register of the current transfer |
| word_idx_o | output | 2 | Long word within the current register (0..2) |

## Verification
Two events can land on the flag in the same cycle: a clear request and a fresh violating access. The bench strobes an out-of-window read together with `viol_clr_i` and expects the flag to read set afterwards. A second collision is a read strobed in the same cycle as a new primitive while the block is idle. That read must be judged illegal, must return zero data, and must not consume the window that the primitive opens, so a following read is checked to be legal and to load the count. A primitive that arrives in the middle of a transfer is also provoked, and the count must drop to zero at once.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;

endpackage

// File: rtl/regsel_popcnt.sv
// Counts the ones in a vector.
module regsel_popcnt #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end

endmodule

// File: rtl/regsel_hibit.sv
// Index of the most significant set bit (zero when none set).
module regsel_hibit #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/regsel_sticky.sv
// Sticky flag; a set request wins over a clear in the same cycle.
module regsel_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/regsel_xfer_seq.sv
module regsel_xfer_seq #(
  parameter int MASK_W        = 8,
  parameter int REG_W         = 16,
  parameter int WORDS_PER_REG = 3,   // must be 2 or more
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        prim_issue_i,
  input  logic [MASK_W-1:0]                           mask_i,
  input  logic                                        rd_stb_i,
  input  logic                                        wr_stb_i,
  input  logic                                        viol_clr_i,
  input  logic                                        xfer_rdy_i,
  output logic [REG_W-1:0]                            rd_data_o,
  output logic                                        viol_o,
  output logic [$clog2(WORDS_PER_REG*MASK_W+1)-1:0]   remain_o,
  output logic [$clog2(MASK_W)-1:0]                   reg_idx_o,
  output logic [$clog2(WORDS_PER_REG)-1:0]            word_idx_o
);

  import regsel_pkg::*;

  localparam int CNT_W  = $clog2(WORDS_PER_REG*MASK_W+1);
  localparam int IDX_W  = $clog2(MASK_W);
  localparam int WIDX_W = $clog2(WORDS_PER_REG);
  localparam int PAD_W  = REG_W - MASK_W;

  // ---------------- reset release synchronizer ----------------
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_s_n = rst_sync_q[SYNC_STAGES-1];

  // ---------------- state ----------------
  seq_state_e         state_q, state_d;
  logic [MASK_W-1:0]  mask_q,  mask_d;
  logic [MASK_W-1:0]  pend_q,  pend_d;
  logic [CNT_W-1:0]   remain_q, remain_d;
  logic [WIDX_W-1:0]  word_q,  word_d;

  logic               win;
  logic               legal_rd;
  logic               bad_rd;
  logic               viol_set;
  logic               step;
  logic               last_word;
  logic               seq_en;
  logic               mask_en;
  logic [CNT_W-1:0]   pop_cnt;
  logic [IDX_W-1:0]   hi_idx;

  regsel_popcnt #(.W(MASK_W), .CW(CNT_W)) u_pop (
    .vec_i (mask_q),
    .cnt_o (pop_cnt)
  );

  regsel_hibit #(.W(MASK_W), .IW(IDX_W)) u_hibit (
    .vec_i (pend_q),
    .idx_o (hi_idx)
  );

  assign win       = (state_q == ST_WIN);
  assign legal_rd  = rd_stb_i && win;
  assign bad_rd    = rd_stb_i && !win;
  assign viol_set  = bad_rd || wr_stb_i;
  assign step      = (state_q == ST_XFER) && xfer_rdy_i;
  assign last_word = (word_q == WIDX_W'(WORDS_PER_REG-1));

  // clock enables
  assign mask_en = prim_issue_i;
  assign seq_en  = prim_issue_i || legal_rd || step;

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    mask_d   = mask_q;
    pend_d   = pend_q;
    remain_d = remain_q;
    word_d   = word_q;
    if (prim_issue_i) begin
      mask_d   = mask_i;
      state_d  = ST_WIN;
      pend_d   = '0;
      remain_d = '0;
      word_d   = '0;
    end else begin
      unique case (state_q)
        ST_WIN: begin
          if (rd_stb_i) begin
            pend_d   = mask_q;
            remain_d = CNT_W'(WORDS_PER_REG) * pop_cnt;
            word_d   = '0;
            state_d  = (pop_cnt != '0) ? ST_XFER : ST_IDLE;
          end
        end
        ST_XFER: begin
          if (xfer_rdy_i) begin
            remain_d = remain_q - CNT_W'(1);
            if (last_word) begin
              word_d = '0;
              pend_d = pend_q & ~(MASK_W'(1) << hi_idx);
            end else begin
              word_d = word_q + WIDX_W'(1);
            end
            if (remain_q == CNT_W'(1)) state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      remain_q <= '0;
      word_q   <= '0;
    end else if (seq_en) begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      remain_q <= remain_d;
      word_q   <= word_d;
    end
  end

  regsel_sticky u_viol (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_i  (viol_set),
    .clr_i  (viol_clr_i),
    .flag_o (viol_o)
  );

  // ---------------- outputs ----------------
  assign rd_data_o  = legal_rd ? {mask_q, {PAD_W{1'b0}}} : '0;
  assign remain_o   = remain_q;
  assign reg_idx_o  = hi_idx;
  assign word_idx_o = word_q;

endmodule

// File: rtl/regsel_xfer_seq_chk.sv
module regsel_xfer_seq_chk #(
  parameter int MASK_W        = 8,
  parameter int REG_W         = 16,
  parameter int WORDS_PER_REG = 3,
  parameter int CNT_W         = 5,
  parameter int WIDX_W        = 2
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              win,
  input logic              prim_issue_i,
  input logic              rd_stb_i,
  input logic              wr_stb_i,
  input logic              viol_clr_i,
  input logic              xfer_rdy_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              viol_o,
  input logic [CNT_W-1:0]  remain_o,
  input logic [WIDX_W-1:0] word_idx_o
);

  localparam int PAD_W = REG_W - MASK_W;

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_data_o[PAD_W-1:0] == '0);

  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(rd_stb_i && win) |-> rd_data_o == '0);

  p_bad_read_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb_i && !win) |=> viol_o);

  p_write_viol_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_stb_i |=> viol_o);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (viol_o && !viol_clr_i) |=> viol_o);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (viol_clr_i && !wr_stb_i && !(rd_stb_i && !win)) |=> !viol_o);

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb_i && win && !prim_issue_i) |=>
      (32'(remain_o) == WORDS_PER_REG * $countones($past(rd_data_o))));

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (remain_o != '0 && xfer_rdy_i && !prim_issue_i) |=>
      (32'(remain_o) == 32'($past(remain_o)) - 1));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!xfer_rdy_i && !prim_issue_i && !(rd_stb_i && win)) |=> $stable(remain_o));

  p_word_range_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    32'(word_idx_o) < WORDS_PER_REG);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    prim_issue_i |=> (remain_o == '0 && word_idx_o == '0));

endmodule

bind regsel_xfer_seq regsel_xfer_seq_chk #(
  .MASK_W        (MASK_W),
  .REG_W         (REG_W),
  .WORDS_PER_REG (WORDS_PER_REG),
  .CNT_W         (CNT_W),
  .WIDX_W        (WIDX_W)
) u_chk (
  .clk          (clk),
  .rst_s_n      (rst_s_n),
  .win          (win),
  .prim_issue_i (prim_issue_i),
  .rd_stb_i     (rd_stb_i),
  .wr_stb_i     (wr_stb_i),
  .viol_clr_i   (viol_clr_i),
  .xfer_rdy_i   (xfer_rdy_i),
  .rd_data_o    (rd_data_o),
  .viol_o       (viol_o),
  .remain_o     (remain_o),
  .word_idx_o   (word_idx_o)
);

// File: tb/regsel_xfer_seq_test.sv
`timescale 1ns/1ps
module regsel_xfer_seq_test;

  logic        clk;
  logic        rst_n;
  logic        prim_issue_i;
  logic [7:0]  mask_i;
  logic        rd_stb_i;
  logic        wr_stb_i;
  logic        viol_clr_i;
  logic        xfer_rdy_i;
  logic [15:0] rd_data_o;
  logic        viol_o;
  logic [4:0]  remain_o;
  logic [2:0]  reg_idx_o;
  logic [1:0]  word_idx_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  regsel_xfer_seq uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .prim_issue_i (prim_issue_i),
    .mask_i       (mask_i),
    .rd_stb_i     (rd_stb_i),
    .wr_stb_i     (wr_stb_i),
    .viol_clr_i   (viol_clr_i),
    .xfer_rdy_i   (xfer_rdy_i),
    .rd_data_o    (rd_data_o),
    .viol_o       (viol_o),
    .remain_o     (remain_o),
    .reg_idx_o    (reg_idx_o),
    .word_idx_o   (word_idx_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {mask, expected number of ones}
  localparam logic [15:0] VEC [8] = '{
    16'h0000, 16'h0101, 16'h8001, 16'hFF08,
    16'hA504, 16'h3C04, 16'h4102, 16'h7F07
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int hi_of(input logic [7:0] m);
    int r = 0;
    for (int b = 7; b >= 0; b--) begin
      if (m[b]) begin
        r = b;
        break;
      end
    end
    return r;
  endfunction

  task automatic issue(input logic [7:0] m);
    prim_issue_i = 1'b1;
    mask_i       = m;
    step();
    prim_issue_i = 1'b0;
  endtask

  task automatic clear_viol();
    viol_clr_i = 1'b1;
    step();
    viol_clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    logic [7:0] pend;
    int n;
    prim_issue_i = 0; mask_i = 0; rd_stb_i = 0; wr_stb_i = 0;
    viol_clr_i = 0; xfer_rdy_i = 0;
    rst_n = 0;
    repeat (3) step();
    // R10: reset state
    chk("R10", "viol", int'(viol_o), 0);
    chk("R10", "remain", int'(remain_o), 0);
    rst_n = 1;
    repeat (4) step();
    chk("R10", "viol", int'(viol_o), 0);
    chk("R10", "remain", int'(remain_o), 0);
    chk("R10", "reg_idx", int'(reg_idx_o), 0);
    chk("R10", "word_idx", int'(word_idx_o), 0);
    chk("R10", "rd_data", int'(rd_data_o), 0);

    // ---------------- table walk ----------------
    for (int i = 0; i < 8; i++) begin
      m = VEC[i][15:8];
      n = int'(VEC[i][7:0]);
      issue(m);
      rd_stb_i = 1'b1;
      #1;
      chk("R1", "rd_data", int'(rd_data_o), int'({m, 8'h00}));
      step();
      rd_stb_i = 1'b0;
      chk("R6", "remain after load", int'(remain_o), 3*n);
      chk("R2", "legal read no viol", int'(viol_o), 0);
      pend = m;
      for (int k = 0; k < 3*n; k++) begin
        chk("R8", "reg_idx", int'(reg_idx_o), hi_of(pend));
        chk("R8", "word_idx", int'(word_idx_o), k % 3);
        xfer_rdy_i = 1'b1;
        step();
        xfer_rdy_i = 1'b0;
        chk("R7", "remain step", int'(remain_o), 3*n - k - 1);
        if (k % 3 == 2) pend[hi_of(pend)] = 1'b0;
      end
      chk("R6", "remain done", int'(remain_o), 0);
      chk("R8", "word_idx done", int'(word_idx_o), 0);
    end

    // ---------------- directed ----------------
    // R3: read with no primitive
    rd_stb_i = 1'b1;
    #1;
    chk("R1", "rd_data illegal", int'(rd_data_o), 0);
    step();
    rd_stb_i = 1'b0;
    chk("R3", "viol after stray read", int'(viol_o), 1);
    repeat (2) step();
    chk("R5", "viol sticky", int'(viol_o), 1);
    clear_viol();
    chk("R5", "viol cleared", int'(viol_o), 0);

    // R3: second read after legal read
    issue(8'h12);
    rd_stb_i = 1'b1; step();
    chk("R3", "first read legal", int'(viol_o), 0);
    #1;
    chk("R1", "second read data", int'(rd_data_o), 0);
    step();
    rd_stb_i = 1'b0;
    chk("R3", "second read viol", int'(viol_o), 1);
    chk("R3", "second read keeps count", int'(remain_o), 6);
    xfer_rdy_i = 1'b1; repeat (6) step(); xfer_rdy_i = 1'b0;
    clear_viol();

    // R4: write inside window, window survives
    issue(8'h04);
    wr_stb_i = 1'b1; step(); wr_stb_i = 1'b0;
    chk("R4", "write viol", int'(viol_o), 1);
    clear_viol();
    rd_stb_i = 1'b1;
    #1;
    chk("R4", "window kept after write", int'(rd_data_o), int'(16'h0400));
    step();
    rd_stb_i = 1'b0;
    chk("R4", "read after write legal", int'(viol_o), 0);
    chk("R4", "count after write", int'(remain_o), 3);
    xfer_rdy_i = 1'b1; repeat (3) step(); xfer_rdy_i = 1'b0;

    // R5: violation and clear in the same cycle
    rd_stb_i = 1'b1; viol_clr_i = 1'b1;
    step();
    rd_stb_i = 1'b0; viol_clr_i = 1'b0;
    chk("R5", "set beats clear", int'(viol_o), 1);
    clear_viol();

    // R2: read in same cycle as primitive from idle
    prim_issue_i = 1'b1; mask_i = 8'h30; rd_stb_i = 1'b1;
    #1;
    chk("R2", "same-cycle read data", int'(rd_data_o), 0);
    step();
    prim_issue_i = 1'b0; rd_stb_i = 1'b0;
    chk("R2", "same-cycle read viol", int'(viol_o), 1);
    clear_viol();
    rd_stb_i = 1'b1;
    #1;
    chk("R2", "later read legal data", int'(rd_data_o), int'(16'h3000));
    step();
    rd_stb_i = 1'b0;
    chk("R2", "later read no viol", int'(viol_o), 0);
    chk("R6", "later read count", int'(remain_o), 6);

    // R7: hold while not ready
    repeat (3) step();
    chk("R7", "hold without ready", int'(remain_o), 6);
    xfer_rdy_i = 1'b1; step(); xfer_rdy_i = 1'b0;
    chk("R7", "one step", int'(remain_o), 5);

    // R9: abort mid-transfer
    issue(8'h81);
    chk("R9", "abort remain", int'(remain_o), 0);
    chk("R9", "abort word", int'(word_idx_o), 0);
    rd_stb_i = 1'b1;
    #1;
    chk("R9", "new mask read", int'(rd_data_o), int'(16'h8100));
    step();
    rd_stb_i = 1'b0;
    chk("R9", "new count", int'(remain_o), 6);
    chk("R8", "top reg first", int'(reg_idx_o), 7);
    xfer_rdy_i = 1'b1; repeat (3) step(); xfer_rdy_i = 1'b0;
    chk("R8", "next reg", int'(reg_idx_o), 0);
    chk("R8", "word wraps", int'(word_idx_o), 0);
    xfer_rdy_i = 1'b1; repeat (3) step();
    chk("R7", "drained", int'(remain_o), 0);
    step();
    xfer_rdy_i = 1'b0;
    chk("R7", "ready when idle", int'(remain_o), 0);
    chk("R5", "no stray viol", int'(viol_o), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule